// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

The unit gathers 64 level-sensitive interrupt lines and 16 legacy ISA-style request lines and hands one of them to a processor as a single pending vectored interrupt. The legacy requests are folded onto five fixed vector numbers. All other legacy requests are dropped. The result is merged with the 64 direct lines.

While the unit is idle, it accepts the lowest-numbered asserted line. Acceptance sets a busy flag in a status byte and raises a hard-interrupt request. It also fills three 64-bit data words that describe the event. The busy latch holds a single entry: further lines are ignored until the accepted line goes low. The busy flag and the request then drop, and the next asserted line can be taken.

Top module: `ivd_dispatch`

## Requirements
- R1: While rst_ni is low, busy, irq_o, status_o and all three data words are zero.
- R2: At a clock edge where the unit is idle and any merged line is high, the unit becomes busy: status_o bit 5 reads 1 and irq_o is 1 after that edge.
- R3: On acceptance, word0_o becomes 0x7C0 OR the line number, which is the 5-bit value 0x1f at bits 10..6 and the line number in bits 5..0. word1_o and word2_o become zero.
- R4: When several merged lines are high at acceptance, the lowest-numbered one is taken.
- R5: While busy, raising or lowering any line other than the accepted one has no effect: the unit stays busy and the data words keep their values.
- R6: At the first edge where the accepted line is low, busy and irq_o clear. The data words keep the values of the last acceptance.
- R7: ISA request 1 drives vector 0x29, 4 drives 0x2b, 6 drives 0x27, 7 drives 0x22 and 12 drives 0x2a.
- R8: The ISA requests 0, 2, 3, 5, 8, 9, 10, 11, 13, 14 and 15 drive no vector and never cause an acceptance.
- R9: Every status_o bit other than bit 5 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vec_lvl_i | input | 64 | Direct vector line levels, line n on bit n |
| isa_req_i | input | 16 | Legacy ISA request levels |
| irq_o | output | 1 | Hard-interrupt request to the processor |
| status_o | output | 8 | Status byte, busy flag on bit 5 |
| word0_o | output | 64 | Data word 0: tag 0x1f at bits 10..6, line number in bits 5..0 |
| word1_o | output | 64 | Data word 1, zero after acceptance |
| word2_o | output | 64 | Data word 2, zero after acceptance |

## Verification
The hardest case to reach from the ports is a handover. One line is being served while another line is still high. When the served line drops, the unit must go idle for exactly one edge and then accept the waiting line. The bench holds two lines high and lowers only the accepted one. It samples after the clearing edge and again after the next edge. It also lowers a non-accepted line while the unit is busy, to show that only the served line releases the latch.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  localparam int STAT_W   = 8;
  localparam int BUSY_BIT = 5;
  localparam int TAG_W    = 5;
  localparam int TAG_LSB  = 6;
  localparam logic [TAG_W-1:0] TAG_VAL = 5'h1f;

  // legacy request -> vector number, -1 = unmapped
  function automatic int isa_target(input int req);
    case (req)
      1:       return 'h29;
      4:       return 'h2b;
      6:       return 'h27;
      7:       return 'h22;
      12:      return 'h2a;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/ivd_isa_map.sv
module ivd_isa_map #(
  parameter int ISA_N = 16,
  parameter int VEC_N = 64
) (
  input  logic [ISA_N-1:0] isa_i,
  output logic [VEC_N-1:0] vec_o
);
  import ivd_pkg::*;

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < ISA_N; i++) begin
      if (isa_target(i) >= 0 && isa_target(i) < VEC_N)
        vec_o[isa_target(i)] = vec_o[isa_target(i)] | isa_i[i];
    end
  end
endmodule

// File: rtl/ivd_pick_low.sv
module ivd_pick_low #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     lines_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lines_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign found_o = |lines_i;
endmodule

// File: rtl/ivd_latch.sv
module ivd_latch #(
  parameter int N      = 64,
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      lines_i,
  input  logic              found_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] w0_o,
  output logic [DATA_W-1:0] w1_o,
  output logic [DATA_W-1:0] w2_o
);
  import ivd_pkg::*;

  logic              busy_q;
  logic [IDX_W-1:0]  line_q;
  logic [DATA_W-1:0] w0_q, w1_q, w2_q, w0_d;

  always_comb begin
    w0_d = '0;
    w0_d[TAG_LSB +: TAG_W] = TAG_VAL;
    w0_d[IDX_W-1:0]        = idx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      line_q <= '0;
      w0_q   <= '0;
      w1_q   <= '0;
      w2_q   <= '0;
    end else if (!busy_q) begin
      if (found_i) begin
        busy_q <= 1'b1;
        line_q <= idx_i;
        w0_q   <= w0_d;
        w1_q   <= '0;
        w2_q   <= '0;
      end
    end else if (!lines_i[line_q]) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign w0_o   = w0_q;
  assign w1_o   = w1_q;
  assign w2_o   = w2_q;

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && found_i) |=> busy_q);
  p_words_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (w1_q == '0 && w2_q == '0 && w0_q[TAG_LSB +: TAG_W] == TAG_VAL));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(w0_q));
  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !lines_i[line_q]) |=> (!busy_q && $stable(w0_q)));
endmodule

// File: rtl/ivd_dispatch.sv
module ivd_dispatch #(
  parameter int VEC_N  = 64,
  parameter int ISA_N  = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VEC_N-1:0]  vec_lvl_i,
  input  logic [ISA_N-1:0]  isa_req_i,
  output logic              irq_o,
  output logic [7:0]        status_o,
  output logic [DATA_W-1:0] word0_o,
  output logic [DATA_W-1:0] word1_o,
  output logic [DATA_W-1:0] word2_o
);
  import ivd_pkg::*;

  localparam int IDX_W = $clog2(VEC_N);

  logic [VEC_N-1:0] isa_vec, merged;
  logic             found, busy;
  logic [IDX_W-1:0] pick;

  ivd_isa_map #(.ISA_N(ISA_N), .VEC_N(VEC_N)) u_map (
    .isa_i (isa_req_i),
    .vec_o (isa_vec)
  );

  assign merged = vec_lvl_i | isa_vec;

  ivd_pick_low #(.N(VEC_N)) u_pick (
    .lines_i (merged),
    .found_o (found),
    .idx_o   (pick)
  );

  ivd_latch #(.N(VEC_N), .DATA_W(DATA_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lines_i (merged),
    .found_i (found),
    .idx_i   (pick),
    .busy_o  (busy),
    .w0_o    (word0_o),
    .w1_o    (word1_o),
    .w2_o    (word2_o)
  );

  always_comb begin
    status_o = '0;
    status_o[BUSY_BIT] = busy;
  end
  assign irq_o = busy;

  p_lowest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> (merged[pick] && (merged & ((VEC_N'(1) << pick) - VEC_N'(1))) == '0));
  p_isa_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isa_vec) <= $countones(isa_req_i));
  p_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_o) <= 1);
endmodule

// File: tb/sim_ivd_dispatch.sv
module sim_ivd_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] vec = '0;
  logic [15:0] isa = '0;
  logic        irq;
  logic [7:0]  stat;
  logic [63:0] w0, w1, w2;
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  ivd_dispatch u0 (
    .clk_i(clk), .rst_ni(rst_n), .vec_lvl_i(vec), .isa_req_i(isa),
    .irq_o(irq), .status_o(stat), .word0_o(w0), .word1_o(w1), .word2_o(w2)
  );

  // {vec, isa, expected word0 (0 = no acceptance)}
  localparam int NV = 11;
  localparam logic [143:0] TBL [NV] = '{
    {64'h1,                 16'h0000, 64'h7C0},
    {64'h8000_0000_0000_0000, 16'h0000, 64'h7FF},
    {64'h0000_0100_0000_0220, 16'h0000, 64'h7C5},
    {64'h0,                 16'h0002, 64'h7E9},
    {64'h0,                 16'h0010, 64'h7EB},
    {64'h0,                 16'h0040, 64'h7E7},
    {64'h0,                 16'h0080, 64'h7E2},
    {64'h0,                 16'h1000, 64'h7EA},
    {64'h0,                 16'h0001, 64'h0},
    {64'h0,                 16'hEF2D, 64'h0},
    {64'h0001_0000_0000_0000, 16'h1000, 64'h7EA}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R1 reset state
    chk("R1 irq", {63'b0, irq}, 64'h0);
    chk("R1 status", {56'b0, stat}, 64'h0);
    chk("R1 word0", w0, 64'h0);
    rst_n = 1'b1;
    step();

    for (int k = 0; k < NV; k++) begin
      vec = TBL[k][143:80];
      isa = TBL[k][79:64];
      step();
      if (TBL[k][63:0] != 64'h0) begin
        chk("R2 busy", {56'b0, stat}, 64'h20);
        chk("R2 irq", {63'b0, irq}, 64'h1);
        chk("R3/R4/R7 word0", w0, TBL[k][63:0]);
        chk("R3 word1", w1, 64'h0);
        chk("R3 word2", w2, 64'h0);
      end else begin
        chk("R8 no accept", {56'b0, stat}, 64'h0);
        chk("R8 irq low", {63'b0, irq}, 64'h0);
      end
      vec = '0;
      isa = '0;
      step();
      chk("R6 release", {63'b0, irq}, 64'h0);
    end

    // R5: other lines ignored while busy
    vec = 64'h8;
    step();
    chk("R3 word0 line3", w0, 64'h7C3);
    vec = 64'hA;
    step();
    chk("R5 still busy", {56'b0, stat}, 64'h20);
    chk("R5 word0 held", w0, 64'h7C3);
    vec = 64'h8;
    step();
    chk("R5 non-active drop", {63'b0, irq}, 64'h1);
    chk("R9 status byte", {56'b0, stat}, 64'h20);
    vec = 64'h0;
    step();
    chk("R6 cleared", {56'b0, stat}, 64'h0);
    chk("R6 word0 kept", w0, 64'h7C3);
    vec = 64'h2;
    step();
    chk("R2 reaccept", w0, 64'h7C1);
    vec = 64'h0;
    step();

    // handover: lines 2 and 7 held, drop 2
    vec = 64'h84;
    step();
    chk("R4 lowest of two", w0, 64'h7C2);
    vec = 64'h80;
    step();
    chk("R6 idle one edge", {63'b0, irq}, 64'h0);
    step();
    chk("R2 handover accept", w0, 64'h7C7);
    chk("R2 handover busy", {63'b0, irq}, 64'h1);

    // R1 reset while busy
    rst_n = 1'b0;
    step();
    chk("R1 mid reset irq", {63'b0, irq}, 64'h0);
    chk("R1 mid reset word0", w0, 64'h0);
    vec = '0;
    rst_n = 1'b1;
    step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule